// File: doc/BRIEF.md
# Lease-Based Segment Allocator

This block hands out segments from a fixed pool of equal-size memory segments to processes, and every grant carries a lease. The lease is counted in activations of the owning process: each time the scheduler activates a process it pulses a tick for that process, and the lease of every segment the process holds drops by one. A process that wants to keep its memory must renew the lease before it runs out. A lease that reaches zero is given back to the pool by a background validator that visits one segment per cycle. Ownership therefore never becomes permanent, and any stray ownership left in the table drains back into the free pool.

The current process issues three requests. An allocation asks for a number of segments and a lease length. An extension renews every segment the process holds. A release gives them all back. Each process may hold one allocation at a time, and a per-process selector records it. The block answers every accepted request one cycle later with a two-bit code. It keeps a running count of free segments, and the validator rewrites that count from the table at the end of every sweep in which no allocation or release took place.

Top module: `lease_seg_alloc`

## Requirements
- R1: After reset every segment is free, `freeCount` equals NUM_SEGS, `respValid` is low, and no process holds an allocation.
- R2: `reqOp` encodes 00 allocate, 01 extend, 10 release and 11 no operation. A request with op 11, or with a process number outside 1..NUM_PROCS, changes nothing and gets no response. Any other request gets `respValid` high in the following cycle.
- R3: An allocation from a process that already holds an allocation is answered with code 01 and changes neither the table nor `freeCount`.
- R4: An allocation whose quantity is zero or larger than `freeCount` is answered with code 10 and changes nothing.
- R5: A granted allocation is answered with code 00. It takes the requested number of free segments, lowest index first. `freeCount` drops by the quantity, and `respSel` shows the lowest granted index, which becomes the requester's selector.
- R6: The lease written by an allocation or an extension is the requested value clamped to the range 1..MAX_LEASE.
- R7: A tick for a process lowers by one every nonzero lease that process owns. Leases owned by other processes stay unchanged.
- R8: A segment whose lease has reached zero returns to the free pool within NUM_SEGS cycles, and `freeCount` rises to match. If that segment was the owner's selector, the selector is cleared so the process can allocate again.
- R9: An extension answers code 00 and reloads the lease of every segment the requester owns.
- R10: A release answers code 00, frees every segment the requester owns, raises `freeCount` by that number and clears the requester's selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe from the current process |
| reqOp | input | 2 | 00 allocate, 01 extend, 10 release, 11 none |
| reqPid | input | PID_W | Requesting process, valid range 1..NUM_PROCS |
| reqQty | input | CNT_W | Segments wanted by an allocation |
| reqLease | input | LEASE_W | Lease length in activations |
| tickValid | input | 1 | Activation tick strobe |
| tickPid | input | PID_W | Process being activated |
| respValid | output | 1 | Response strobe, one cycle after the request |
| respCode | output | 2 | 00 granted, 01 already holding, 10 not enough segments |
| respSel | output | SEG_W | Lowest segment index of a grant |
| freeCount | output | CNT_W | Current number of free segments |

## Verification
The bench builds the block with eight segments, four processes and a lease ceiling of 5. With these values a three-bit lease request of 7 is above the ceiling, so the clamp can be tested, and a process number of 0 can be driven to test the out-of-range filter. Each validator sweep lasts only eight cycles, so reclaim waits stay short. The tests cover leases that age to zero, leases renewed just before expiry, ticks aimed at a process that holds nothing, and exhaustion of the whole pool, all within a few hundred cycles.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC  = 2'b00,
    OP_EXTEND = 2'b01,
    OP_FREE   = 2'b10,
    OP_NONE   = 2'b11
  } op_e;

  localparam logic [1:0] RSP_GRANT   = 2'b00;
  localparam logic [1:0] RSP_HOLDING = 2'b01;
  localparam logic [1:0] RSP_SHORT   = 2'b10;

  // strobes from control to the segment table
  typedef struct packed {
    logic alloc;
    logic extend;
    logic release_all;
    logic tick;
  } tbl_strobe_t;

endpackage

// File: rtl/lsa_table.sv
module lsa_table
  import lsa_pkg::*;
#(
  parameter int NUM_SEGS  = 8,
  parameter int NUM_PROCS = 4,
  parameter int MAX_LEASE = 15,
  localparam int SEG_W   = $clog2(NUM_SEGS),
  localparam int PID_W   = $clog2(NUM_PROCS + 1),
  localparam int LEASE_W = $clog2(MAX_LEASE + 1),
  localparam int CNT_W   = $clog2(NUM_SEGS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tbl_strobe_t        strb,
  input  logic [PID_W-1:0]   reqPid,
  input  logic [CNT_W-1:0]   reqQty,
  input  logic [LEASE_W-1:0] leaseVal,
  input  logic [PID_W-1:0]   tickPid,
  input  logic [SEG_W-1:0]   sweepIdx,
  output logic [CNT_W-1:0]   grantCnt,
  output logic [SEG_W-1:0]   firstGrant,
  output logic [CNT_W-1:0]   releaseCnt,
  output logic               reclaimNow,
  output logic [PID_W-1:0]   sweepOwner,
  output logic               sweepFreeNext
);

  localparam logic [PID_W-1:0]   NO_OWNER = '0;
  localparam logic [PID_W-1:0]   MAX_PID  = PID_W'(NUM_PROCS);
  localparam logic [LEASE_W-1:0] MAX_L    = LEASE_W'(MAX_LEASE);

  logic [PID_W-1:0]   ownerR [NUM_SEGS];
  logic [LEASE_W-1:0] leaseR [NUM_SEGS];

  logic [NUM_SEGS-1:0] grantMask, extendHit, releaseMask, tickHit, reclaimHit, touched;

  always_comb begin
    logic [CNT_W-1:0] freeSeen;
    freeSeen = '0;
    for (int s = 0; s < NUM_SEGS; s++) begin
      logic isFree, isMine, isHit;
      isFree  = (ownerR[s] == NO_OWNER);
      isMine  = !isFree && (ownerR[s] == reqPid);
      isHit   = !isFree && (ownerR[s] == tickPid);
      grantMask[s]   = strb.alloc && isFree && (freeSeen < reqQty);
      extendHit[s]   = strb.extend && isMine;
      releaseMask[s] = strb.release_all && isMine;
      tickHit[s]     = strb.tick && isHit;
      touched[s]     = grantMask[s] | extendHit[s] | releaseMask[s];
      reclaimHit[s]  = (sweepIdx == SEG_W'(s)) && !isFree && !touched[s] &&
                       ((leaseR[s] == '0) || (ownerR[s] > MAX_PID));
      freeSeen = freeSeen + CNT_W'(isFree);
    end
  end

  always_comb begin
    grantCnt   = '0;
    releaseCnt = '0;
    firstGrant = '0;
    for (int s = NUM_SEGS - 1; s >= 0; s--) begin
      grantCnt   = grantCnt + CNT_W'(grantMask[s]);
      releaseCnt = releaseCnt + CNT_W'(releaseMask[s]);
      if (grantMask[s]) firstGrant = SEG_W'(s);
    end
  end

  assign reclaimNow = |reclaimHit;
  assign sweepOwner = ownerR[sweepIdx];
  assign sweepFreeNext = (ownerR[sweepIdx] == NO_OWNER) ? !grantMask[sweepIdx]
                       : (reclaimHit[sweepIdx] | releaseMask[sweepIdx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SEGS; s++) begin
        ownerR[s] <= NO_OWNER;
        leaseR[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_SEGS; s++) begin
        if (grantMask[s]) begin
          ownerR[s] <= reqPid;
          leaseR[s] <= leaseVal;
        end else if (extendHit[s]) begin
          leaseR[s] <= leaseVal;
        end else if (releaseMask[s] || reclaimHit[s]) begin
          ownerR[s] <= NO_OWNER;
          leaseR[s] <= '0;
        end else if (tickHit[s] && (leaseR[s] != '0)) begin
          leaseR[s] <= leaseR[s] - 1'b1;
        end
      end
    end
  end

  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    strb.alloc |-> (grantCnt == reqQty)); // R5

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_segChk
    AST_LEASE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ownerR[g] != NO_OWNER) |-> (leaseR[g] <= MAX_L) && (leaseR[g] != '0 || !$past(grantMask[g]))); // R6
    AST_RECLAIM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      reclaimHit[g] |=> (ownerR[g] == NO_OWNER)); // R8
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tickHit[g] && !touched[g] && !reclaimHit[g] && leaseR[g] != '0)
        |=> (leaseR[g] == $past(leaseR[g]) - 1'b1)); // R7
  end

endmodule

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
#(
  parameter int NUM_SEGS  = 8,
  parameter int NUM_PROCS = 4,
  parameter int MAX_LEASE = 15,
  localparam int SEG_W   = $clog2(NUM_SEGS),
  localparam int PID_W   = $clog2(NUM_PROCS + 1),
  localparam int LEASE_W = $clog2(MAX_LEASE + 1),
  localparam int CNT_W   = $clog2(NUM_SEGS + 1),
  localparam int NPID    = 2 ** PID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [PID_W-1:0]   reqPid,
  input  logic [CNT_W-1:0]   reqQty,
  input  logic [LEASE_W-1:0] reqLease,
  input  logic               tickValid,
  input  logic [CNT_W-1:0]   grantCnt,
  input  logic [SEG_W-1:0]   firstGrant,
  input  logic [CNT_W-1:0]   releaseCnt,
  input  logic               reclaimNow,
  input  logic [PID_W-1:0]   sweepOwner,
  input  logic               sweepFreeNext,
  output tbl_strobe_t        strb,
  output logic [LEASE_W-1:0] leaseVal,
  output logic [SEG_W-1:0]   sweepIdx,
  output logic               respValid,
  output logic [1:0]         respCode,
  output logic [SEG_W-1:0]   respSel,
  output logic [CNT_W-1:0]   freeCount
);

  localparam logic [PID_W-1:0]   MAX_PID  = PID_W'(NUM_PROCS);
  localparam logic [LEASE_W-1:0] MAX_L    = LEASE_W'(MAX_LEASE);
  localparam logic [SEG_W-1:0]   LAST_SEG = SEG_W'(NUM_SEGS - 1);
  localparam logic [CNT_W-1:0]   ALL_SEGS = CNT_W'(NUM_SEGS);

  logic             selValid [NPID];
  logic [SEG_W-1:0] selIdx   [NPID];
  logic [CNT_W-1:0] freeCnt, tally, freeNext;
  logic             dirty;

  logic pidOk, accepted, isAlloc, holding, shortFall;
  op_e  op;

  assign op        = op_e'(reqOp);
  assign pidOk     = (reqPid != '0) && (reqPid <= MAX_PID);
  assign accepted  = reqValid && pidOk && (op != OP_NONE);
  assign isAlloc   = accepted && (op == OP_ALLOC);
  assign holding   = selValid[reqPid];
  assign shortFall = (reqQty == '0) || (reqQty > freeCnt);

  always_comb begin
    strb.alloc       = isAlloc && !holding && !shortFall;
    strb.extend      = accepted && (op == OP_EXTEND);
    strb.release_all = accepted && (op == OP_FREE);
    strb.tick        = tickValid;
  end

  assign leaseVal = (reqLease == '0) ? LEASE_W'(1) : ((reqLease > MAX_L) ? MAX_L : reqLease);
  assign freeNext = freeCnt - grantCnt + releaseCnt + CNT_W'(reclaimNow);
  assign freeCount = freeCnt;

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respCode  <= RSP_GRANT;
      respSel   <= '0;
    end else begin
      respValid <= accepted;
      if (accepted) begin
        if (isAlloc && holding)        respCode <= RSP_HOLDING;
        else if (isAlloc && shortFall) respCode <= RSP_SHORT;
        else                           respCode <= RSP_GRANT;
        if (strb.alloc) respSel <= firstGrant;
      end
    end
  end

  // per-process selectors
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPID; p++) begin
        selValid[p] <= 1'b0;
        selIdx[p]   <= '0;
      end
    end else begin
      for (int p = 1; p < NPID; p++) begin
        if (strb.alloc && reqPid == PID_W'(p)) begin
          selValid[p] <= 1'b1;
          selIdx[p]   <= firstGrant;
        end else if (strb.release_all && reqPid == PID_W'(p)) begin
          selValid[p] <= 1'b0;
        end else if (selValid[p] && selIdx[p] == sweepIdx &&
                     (sweepOwner != PID_W'(p) || reclaimNow)) begin
          selValid[p] <= 1'b0;
        end
      end
    end
  end

  // free counter and validator sweep
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeCnt  <= ALL_SEGS;
      tally    <= '0;
      dirty    <= 1'b0;
      sweepIdx <= '0;
    end else if (sweepIdx == LAST_SEG) begin
      sweepIdx <= '0;
      tally    <= '0;
      dirty    <= 1'b0;
      if (!(dirty || strb.alloc || strb.release_all)) freeCnt <= tally + CNT_W'(sweepFreeNext);
      else                                             freeCnt <= freeNext;
    end else begin
      sweepIdx <= sweepIdx + 1'b1;
      tally    <= tally + CNT_W'(sweepFreeNext);
      dirty    <= dirty | strb.alloc | strb.release_all;
      freeCnt  <= freeNext;
    end
  end

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    freeCnt <= ALL_SEGS); // R5
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accepted |=> !respValid); // R2
  AST_HOLD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (isAlloc && holding) |=> (respValid && respCode == RSP_HOLDING)); // R3
  AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (isAlloc && !holding && shortFall) |=> (respValid && respCode == RSP_SHORT)); // R4
  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    strb.alloc |=> ({1'b0, freeCnt} + {1'b0, $past(reqQty)} <= {1'b0, $past(freeCnt)} + 1'b1)); // R5

endmodule

// File: rtl/lease_seg_alloc.sv
module lease_seg_alloc
  import lsa_pkg::*;
#(
  parameter int NUM_SEGS  = 8,
  parameter int NUM_PROCS = 4,
  parameter int MAX_LEASE = 15,
  localparam int SEG_W   = $clog2(NUM_SEGS),
  localparam int PID_W   = $clog2(NUM_PROCS + 1),
  localparam int LEASE_W = $clog2(MAX_LEASE + 1),
  localparam int CNT_W   = $clog2(NUM_SEGS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [PID_W-1:0]   reqPid,
  input  logic [CNT_W-1:0]   reqQty,
  input  logic [LEASE_W-1:0] reqLease,
  input  logic               tickValid,
  input  logic [PID_W-1:0]   tickPid,
  output logic               respValid,
  output logic [1:0]         respCode,
  output logic [SEG_W-1:0]   respSel,
  output logic [CNT_W-1:0]   freeCount
);

  tbl_strobe_t        strb;
  logic [LEASE_W-1:0] leaseVal;
  logic [SEG_W-1:0]   sweepIdx, firstGrant;
  logic [CNT_W-1:0]   grantCnt, releaseCnt;
  logic               reclaimNow, sweepFreeNext;
  logic [PID_W-1:0]   sweepOwner;

  lsa_ctrl #(.NUM_SEGS(NUM_SEGS), .NUM_PROCS(NUM_PROCS), .MAX_LEASE(MAX_LEASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqOp(reqOp), .reqPid(reqPid), .reqQty(reqQty),
    .reqLease(reqLease), .tickValid(tickValid),
    .grantCnt(grantCnt), .firstGrant(firstGrant), .releaseCnt(releaseCnt),
    .reclaimNow(reclaimNow), .sweepOwner(sweepOwner), .sweepFreeNext(sweepFreeNext),
    .strb(strb), .leaseVal(leaseVal), .sweepIdx(sweepIdx),
    .respValid(respValid), .respCode(respCode), .respSel(respSel), .freeCount(freeCount)
  );

  lsa_table #(.NUM_SEGS(NUM_SEGS), .NUM_PROCS(NUM_PROCS), .MAX_LEASE(MAX_LEASE)) u_table (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .reqPid(reqPid), .reqQty(reqQty), .leaseVal(leaseVal), .tickPid(tickPid),
    .sweepIdx(sweepIdx),
    .grantCnt(grantCnt), .firstGrant(firstGrant), .releaseCnt(releaseCnt),
    .reclaimNow(reclaimNow), .sweepOwner(sweepOwner), .sweepFreeNext(sweepFreeNext)
  );

endmodule

// File: tb/lease_seg_alloc_tb.sv
module lease_seg_alloc_tb;

  localparam int NS = 8, NP = 4, ML = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqOp = 2'b11;
  logic [2:0] reqPid = '0;
  logic [3:0] reqQty = '0;
  logic [2:0] reqLease = '0;
  logic       tickValid = 1'b0;
  logic [2:0] tickPid = '0;
  logic       respValid;
  logic [1:0] respCode;
  logic [2:0] respSel;
  logic [3:0] freeCount;

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lease_seg_alloc #(.NUM_SEGS(NS), .NUM_PROCS(NP), .MAX_LEASE(ML)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqPid(reqPid),
    .reqQty(reqQty), .reqLease(reqLease), .tickValid(tickValid), .tickPid(tickPid),
    .respValid(respValid), .respCode(respCode), .respSel(respSel), .freeCount(freeCount)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] pid;
    logic [3:0] qty;
    logic [2:0] lease;
    logic       expValid;
    logic [1:0] expCode;
    logic [2:0] expSel;
    logic [3:0] expFree;
    logic [3:0] reqNum;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 3'd1, 4'd3, 3'd2, 1'b1, 2'b00, 3'd0, 4'd5, 4'd5},  // R5 grant 0..2
    '{2'b00, 3'd1, 4'd1, 3'd2, 1'b1, 2'b01, 3'd0, 4'd5, 4'd3},  // R3 already holding
    '{2'b00, 3'd2, 4'd6, 3'd3, 1'b1, 2'b10, 3'd0, 4'd5, 4'd4},  // R4 too many
    '{2'b00, 3'd2, 4'd5, 3'd7, 1'b1, 2'b00, 3'd3, 4'd0, 4'd5},  // R5 grant 3..7, lease clamps (R6)
    '{2'b00, 3'd3, 4'd1, 3'd3, 1'b1, 2'b10, 3'd0, 4'd0, 4'd4},  // R4 pool empty
    '{2'b10, 3'd1, 4'd0, 3'd0, 1'b1, 2'b00, 3'd0, 4'd3, 4'd10}, // R10 release p1
    '{2'b00, 3'd3, 4'd0, 3'd3, 1'b1, 2'b10, 3'd0, 4'd3, 4'd4},  // R4 zero quantity
    '{2'b00, 3'd3, 4'd2, 3'd3, 1'b1, 2'b00, 3'd0, 4'd1, 4'd5},  // R5 grant 0..1
    '{2'b11, 3'd4, 4'd1, 3'd3, 1'b0, 2'b00, 3'd0, 4'd1, 4'd2},  // R2 no-op code
    '{2'b00, 3'd0, 4'd1, 3'd3, 1'b0, 2'b00, 3'd0, 4'd1, 4'd2}   // R2 pid zero
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] pid,
                       input logic [3:0] qty, input logic [2:0] lease);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqPid = pid; reqQty = qty; reqLease = lease;
    @(negedge clk);
    reqValid = 1'b0; reqOp = 2'b11;
  endtask

  task automatic tick(input logic [2:0] pid, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tickValid = 1'b1; tickPid = pid;
      @(negedge clk);
      tickValid = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    idle(3);
    chk("R1", "freeCount in reset", int'(freeCount), NS);
    chk("R1", "respValid in reset", int'(respValid), 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1", "freeCount after reset", int'(freeCount), NS);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].reqNum);
      issue(VECS[i].op, VECS[i].pid, VECS[i].qty, VECS[i].lease);
      chk(tag, $sformatf("vec%0d respValid", i), int'(respValid), int'(VECS[i].expValid));
      if (VECS[i].expValid) chk(tag, $sformatf("vec%0d respCode", i), int'(respCode), int'(VECS[i].expCode));
      if (VECS[i].expValid && VECS[i].expCode == 2'b00 && VECS[i].op == 2'b00)
        chk(tag, $sformatf("vec%0d respSel", i), int'(respSel), int'(VECS[i].expSel));
      chk(tag, $sformatf("vec%0d freeCount", i), int'(freeCount), int'(VECS[i].expFree));
    end

    // R9 renewal before expiry, R7 ticks for another process do nothing
    tick(3'd3, 2);
    issue(2'b01, 3'd3, 4'd0, 3'd2);
    chk("R9", "extend code", int'(respCode), 0);
    tick(3'd3, 1);
    tick(3'd1, 5);
    idle(12);
    chk("R9", "renewed lease still held", int'(freeCount), 1);
    tick(3'd3, 1);
    idle(12);
    chk("R8", "expired p3 reclaimed", int'(freeCount), 3);
    issue(2'b00, 3'd3, 4'd1, 3'd4);
    chk("R8", "selector cleared, realloc code", int'(respCode), 0);
    chk("R8", "realloc sel", int'(respSel), 0);
    chk("R5", "realloc freeCount", int'(freeCount), 2);

    // R6 lease request 7 clamped to 5
    tick(3'd2, 4);
    idle(12);
    chk("R6", "clamped lease not yet out", int'(freeCount), 2);
    tick(3'd2, 1);
    idle(12);
    chk("R7", "five ticks expire p2", int'(freeCount), 7);

    // R6 zero lease becomes one
    issue(2'b00, 3'd4, 4'd1, 3'd0);
    chk("R6", "zero lease grant code", int'(respCode), 0);
    chk("R5", "zero lease grant sel", int'(respSel), 1);
    idle(12);
    chk("R6", "zero lease held", int'(freeCount), 6);
    tick(3'd4, 1);
    idle(12);
    chk("R6", "one tick expires", int'(freeCount), 7);

    // R8 expired owner may allocate again, whole remaining pool
    issue(2'b00, 3'd2, 4'd7, 3'd1);
    chk("R8", "p2 realloc code", int'(respCode), 0);
    chk("R5", "p2 realloc sel", int'(respSel), 1);
    chk("R5", "pool exhausted", int'(freeCount), 0);
    issue(2'b00, 3'd2, 4'd1, 3'd1);
    chk("R3", "p2 second alloc", int'(respCode), 1);

    // R10 release returns all seven
    issue(2'b10, 3'd2, 4'd0, 3'd0);
    chk("R10", "release code", int'(respCode), 0);
    chk("R10", "release freeCount", int'(freeCount), 7);

    // R1 reset in mid-run empties the table
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    chk("R1", "respValid in second reset", int'(respValid), 0);
    rst_n = 1'b1;
    issue(2'b00, 3'd3, 4'd8, 3'd5);
    chk("R1", "full grant after reset code", int'(respCode), 0);
    chk("R1", "full grant after reset free", int'(freeCount), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule